// File: doc/BRIEF.md
# Four-Way Set-Associative Line Cache with Register Test Port

This block is an 8 KB unified cache: 128 sets of four ways, each line holding four 32-bit words. A doubleword lookup reports a hit and the addressed word one cycle later. A line is brought in by a four-beat fill, one word per beat in ascending word order. The line lands in the lowest-numbered invalid way of its set, or in the way picked by a three-bit pseudo-LRU tree when the set is full. Three inputs gate caching: a global cache-off bit, a per-page no-cache attribute and an external cacheable qualifier for fills. A flush input empties the whole cache in one cycle.

Software reaches the arrays through three 32-bit test registers. A data register is backed by a four-word write buffer and a four-word read buffer. A status register carries tag, valid and LRU information. A control register holds a set number, an entry number and a two-bit command. Writing the control register runs its command at once. The command can move the write buffer into a chosen way, copy a chosen way into the read buffer and status register, or flush.

Address layout (word address, bits 31:2): bits 3:2 pick the word, bits 10:4 the set, and bits 31:11 form the 21-bit tag.

Top module: `tc_cache`

## Requirements
- R1: A lookup (lk_req high) whose tag matches a valid way of its set gives lk_hit = 1 on the next cycle, with lk_data equal to word addr[3:2] of that line; with lk_req low, lk_hit is 0 on the next cycle.
- R2: A lookup whose tag matches no valid way of its set gives lk_hit = 0 on the next cycle.
- R3: A fill is four fill_valid beats of one line, carrying words 0, 1, 2, 3 in that order. The line is installed on the fourth beat, in the lowest-numbered invalid way of the set when one exists.
- R4: In a full set the victim follows a pseudo-LRU tree {b2,b1,b0}. b0 = 0 picks ways 0/1 (b1 = 0 gives way 0, 1 gives way 1); b0 = 1 picks ways 2/3 (b2 = 0 gives way 2, 1 gives way 3). A hit or fill into way w sets b0 = (w < 2), and sets b1 = (w == 0) for w < 2 or b2 = (w == 2) for w >= 2.
- R5: With cache_off = 1 a lookup misses, and a fill whose first beat sees cache_off = 1 installs nothing.
- R6: With page_nc = 1 a lookup misses, and a fill whose first beat sees page_nc = 1 installs nothing, even when ext_cacheable is 1.
- R7: A fill whose first beat sees ext_cacheable = 0 installs nothing.
- R8: A flush_i pulse clears every valid bit and every LRU tree, so any later lookup misses until a new line is installed.
- R9: tp_sel encodes 0 = data, 1 = status, 2 = control. A data write stores the word into write-buffer word [control bits 3:2]. A data read returns read-buffer word [control bits 3:2]. Command 00 (control bits 1:0) only updates the control register.
- R10: Command 01 writes the write buffer (word k into line word k) into way [control bits 3:2] of set [control bits 10:4]. It takes the tag from status bits 20:0 and the valid bit from status bit 21, and leaves the LRU unchanged.
- R11: Command 10 copies way [3:2] of set [10:4] into the read buffer and loads the status register with tag in 20:0, that way's valid bit in 21, the set's LRU {b2,b1,b0} in 24:22, the set's four valid bits (way n at bit 25+n) in 28:25, and zero in 31:29.
- R12: Command 11 flushes the cache exactly as flush_i does.
- R13: After reset every line is invalid, lk_hit is 0, and the data, status and control registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 30 | Lookup word address (bits 31:2) |
| cache_off | input | 1 | Global cache disable |
| page_nc | input | 1 | Page no-cache attribute of the current access |
| lk_hit | output | 1 | Registered hit result |
| lk_data | output | 32 | Registered hit word |
| fill_valid | input | 1 | Fill beat strobe |
| fill_addr | input | 28 | Fill line address (bits 31:4) |
| fill_data | input | 32 | Fill beat word |
| ext_cacheable | input | 1 | External cacheable qualifier, sampled on the first fill beat |
| flush_i | input | 1 | Invalidate the whole cache |
| tp_wr | input | 1 | Test register write strobe |
| tp_sel | input | 2 | Test register select |
| tp_wdata | input | 32 | Test register write data |
| tp_rdata | output | 32 | Test register read data |

## Verification
The assertions assume that a fill never targets a line that is already resident, and that a test write never sets a valid tag already held by another way of the same set. Together these keep at most one way matching a lookup. They also assume that a fill burst is not overlapped by another fill, a test write or a flush. The stimulus consults its own model before every fill and test line write. It turns a would-be duplicate fill into a lookup and clears the valid bit of a would-be duplicate test write. It also runs each operation to completion before starting the next.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int WORDS    = 4;
    localparam int WAYS     = 4;
    localparam int SETS     = 128;
    localparam int OFS_W    = $clog2(WORDS);
    localparam int SET_W    = $clog2(SETS);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int LINE_LSB = OFS_W + 2;
    localparam int TAG_W    = ADDR_W - SET_W - LINE_LSB;
    localparam int LINE_W   = WORD_W * WORDS;
    localparam int LRU_W    = WAYS - 1;
    localparam int STAT_RSV = WORD_W - WAYS - LRU_W - 1 - TAG_W;
    localparam int CTRL_RSV = WORD_W - SET_W - WAY_W - 2;

    localparam logic [1:0] TP_DATA = 2'd0;
    localparam logic [1:0] TP_STAT = 2'd1;
    localparam logic [1:0] TP_CTRL = 2'd2;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [LRU_W-1:0]  plru_t;

    typedef enum logic [1:0] {
        CMD_BUF    = 2'b00,
        CMD_WRLINE = 2'b01,
        CMD_RDLINE = 2'b10,
        CMD_FLUSH  = 2'b11
    } tcmd_e;

    typedef struct packed {
        tag_t             tag;
        logic [SET_W-1:0] set;
        logic [OFS_W-1:0] word;
    } addr_f_t;

    typedef struct packed {
        logic [STAT_RSV-1:0] rsv;
        logic [WAYS-1:0]     way_vld;
        plru_t               lru;
        logic                vld;
        tag_t                tag;
    } stat_t;

    typedef struct packed {
        logic [CTRL_RSV-1:0] rsv;
        logic [SET_W-1:0]    set;
        logic [WAY_W-1:0]    entry;
        logic [1:0]          cmd;
    } ctrl_t;

    function automatic addr_f_t split_waddr(input logic [ADDR_W-1:2] a);
        addr_f_t f;
        f.tag  = a[ADDR_W-1 -: TAG_W];
        f.set  = a[LINE_LSB +: SET_W];
        f.word = a[2 +: OFS_W];
        return f;
    endfunction
endpackage

// File: rtl/tc_match.sv
module tc_match
    import tc_pkg::*;
(
    input  tag_t [WAYS-1:0]  way_tags,
    input  logic [WAYS-1:0]  way_vld,
    input  tag_t             tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_vld[w] && (way_tags[w] == tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tc_victim.sv
module tc_victim
    import tc_pkg::*;
(
    input  plru_t            lru,
    input  logic [WAYS-1:0]  vld,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] tree_way;

    assign tree_way = lru[0] ? (lru[2] ? WAY_W'(3) : WAY_W'(2))
                             : (lru[1] ? WAY_W'(1) : WAY_W'(0));

    always_comb begin
        victim = tree_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tc_plru_touch.sv
module tc_plru_touch
    import tc_pkg::*;
(
    input  plru_t            lru,
    input  logic [WAY_W-1:0] way,
    output plru_t            lru_next
);
    always_comb begin
        lru_next    = lru;
        lru_next[0] = ~way[1];
        if (!way[1]) lru_next[1] = ~way[0];
        else         lru_next[2] = ~way[0];
    end
endmodule

// File: rtl/tc_cache.sv
module tc_cache
    import tc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lk_req,
    input  logic [ADDR_W-1:2]        lk_addr,
    input  logic                     cache_off,
    input  logic                     page_nc,
    output logic                     lk_hit,
    output logic [WORD_W-1:0]        lk_data,
    input  logic                     fill_valid,
    input  logic [ADDR_W-1:LINE_LSB] fill_addr,
    input  logic [WORD_W-1:0]        fill_data,
    input  logic                     ext_cacheable,
    input  logic                     flush_i,
    input  logic                     tp_wr,
    input  logic [1:0]               tp_sel,
    input  logic [WORD_W-1:0]        tp_wdata,
    output logic [WORD_W-1:0]        tp_rdata
);
    // storage
    line_t           data_mem [WAYS][SETS];
    tag_t            tag_mem  [WAYS][SETS];
    logic [WAYS-1:0] vld_q    [SETS];
    plru_t           lru_q    [SETS];

    // test port decode
    ctrl_t       ctrl_q, ctrl_w;
    stat_t       stat_q;
    logic [WORD_W-1:0] tp_fbuf [WORDS];
    logic [WORD_W-1:0] tp_rbuf [WORDS];
    line_t       tp_line, rd_line;
    logic        ctrl_wr, tline_wr, tline_rd, flush_any;

    assign ctrl_w    = ctrl_t'(tp_wdata);
    assign ctrl_wr   = tp_wr && (tp_sel == TP_CTRL);
    assign tline_wr  = ctrl_wr && (tcmd_e'(ctrl_w.cmd) == CMD_WRLINE);
    assign tline_rd  = ctrl_wr && (tcmd_e'(ctrl_w.cmd) == CMD_RDLINE);
    assign flush_any = flush_i || (ctrl_wr && (tcmd_e'(ctrl_w.cmd) == CMD_FLUSH));
    assign rd_line   = data_mem[ctrl_w.entry][ctrl_w.set];

    for (genvar k = 0; k < WORDS; k++) begin : g_tpl
        assign tp_line[k*WORD_W +: WORD_W] = tp_fbuf[k];
    end

    // lookup path
    addr_f_t          lk_f;
    tag_t [WAYS-1:0]  lk_tags;
    logic [WAYS-1:0]  lk_hit_vec;
    logic             lk_match, lk_take;
    logic [WAY_W-1:0] lk_way;
    plru_t            lk_lru_nx;
    line_t            lk_line;

    assign lk_f = split_waddr(lk_addr);
    always_comb begin
        for (int w = 0; w < WAYS; w++) lk_tags[w] = tag_mem[w][lk_f.set];
    end

    tc_match u_match (
        .way_tags (lk_tags),
        .way_vld  (vld_q[lk_f.set]),
        .tag      (lk_f.tag),
        .hit_vec  (lk_hit_vec),
        .hit      (lk_match),
        .hit_way  (lk_way)
    );

    tc_plru_touch u_touch_lk (
        .lru      (lru_q[lk_f.set]),
        .way      (lk_way),
        .lru_next (lk_lru_nx)
    );

    assign lk_take = lk_req && lk_match && !cache_off && !page_nc && !flush_any;
    assign lk_line = data_mem[lk_way][lk_f.set];

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit  <= 1'b0;
            lk_data <= '0;
        end else begin
            lk_hit <= lk_take;
            if (lk_take) lk_data <= lk_line[int'(lk_f.word)*WORD_W +: WORD_W];
        end
    end

    // fill path
    logic [OFS_W-1:0]  fl_cnt;
    tag_t              fl_tag_q;
    logic [SET_W-1:0]  fl_set_q;
    logic              fl_ok_q, fl_last, fl_commit;
    logic [WORD_W-1:0] fl_buf [WORDS-1];
    logic [WAY_W-1:0]  fl_way;
    plru_t             fl_lru_nx;
    line_t             fl_line;

    assign fl_last   = fill_valid && (fl_cnt == OFS_W'(WORDS - 1));
    assign fl_commit = fl_last && fl_ok_q && !flush_any;

    for (genvar k = 0; k < WORDS; k++) begin : g_fl
        if (k == WORDS - 1) begin : g_tail
            assign fl_line[k*WORD_W +: WORD_W] = fill_data;
        end else begin : g_body
            assign fl_line[k*WORD_W +: WORD_W] = fl_buf[k];
        end
    end

    tc_victim u_victim (
        .lru    (lru_q[fl_set_q]),
        .vld    (vld_q[fl_set_q]),
        .victim (fl_way)
    );

    tc_plru_touch u_touch_fl (
        .lru      (lru_q[fl_set_q]),
        .way      (fl_way),
        .lru_next (fl_lru_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_cnt   <= '0;
            fl_ok_q  <= 1'b0;
            fl_tag_q <= '0;
            fl_set_q <= '0;
            for (int k = 0; k < WORDS - 1; k++) fl_buf[k] <= '0;
        end else if (fill_valid) begin
            if (fl_cnt == '0) begin
                fl_tag_q <= fill_addr[ADDR_W-1 -: TAG_W];
                fl_set_q <= fill_addr[LINE_LSB +: SET_W];
                fl_ok_q  <= ext_cacheable && !cache_off && !page_nc;
            end
            if (!fl_last) fl_buf[fl_cnt] <= fill_data;
            fl_cnt <= fl_cnt + 1'b1;
        end
    end

    // array writes
    always_ff @(posedge clk) begin
        if (tline_wr) begin
            tag_mem [ctrl_w.entry][ctrl_w.set] <= stat_q.tag;
            data_mem[ctrl_w.entry][ctrl_w.set] <= tp_line;
        end
        if (fl_commit) begin
            tag_mem [fl_way][fl_set_q] <= fl_tag_q;
            data_mem[fl_way][fl_set_q] <= fl_line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_any) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                lru_q[s] <= '0;
            end
        end else begin
            if (lk_take)  lru_q[lk_f.set] <= lk_lru_nx;
            if (tline_wr) vld_q[ctrl_w.set][ctrl_w.entry] <= stat_q.vld;
            if (fl_commit) begin
                vld_q[fl_set_q][fl_way] <= 1'b1;
                lru_q[fl_set_q]         <= fl_lru_nx;
            end
        end
    end

    // test registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            for (int k = 0; k < WORDS; k++) begin
                tp_fbuf[k] <= '0;
                tp_rbuf[k] <= '0;
            end
        end else if (tp_wr) begin
            case (tp_sel)
                TP_DATA: tp_fbuf[ctrl_q.entry] <= tp_wdata;
                TP_STAT: begin
                    stat_q     <= stat_t'(tp_wdata);
                    stat_q.rsv <= '0;
                end
                TP_CTRL: begin
                    ctrl_q     <= ctrl_w;
                    ctrl_q.rsv <= '0;
                    if (tline_rd) begin
                        for (int k = 0; k < WORDS; k++)
                            tp_rbuf[k] <= rd_line[k*WORD_W +: WORD_W];
                        stat_q <= '{rsv:     '0,
                                    way_vld: vld_q[ctrl_w.set],
                                    lru:     lru_q[ctrl_w.set],
                                    vld:     vld_q[ctrl_w.set][ctrl_w.entry],
                                    tag:     tag_mem[ctrl_w.entry][ctrl_w.set]};
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (tp_sel)
            TP_DATA: tp_rdata = tp_rbuf[ctrl_q.entry];
            TP_STAT: tp_rdata = stat_q;
            TP_CTRL: tp_rdata = ctrl_q;
            default: tp_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tc_cache_chk.sv
module tc_cache_chk
    import tc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_req,
    input logic            lk_hit,
    input logic            cache_off,
    input logic            page_nc,
    input logic            flush_i,
    input logic            tp_wr,
    input logic [1:0]      tp_sel,
    input logic [1:0]      tp_cmd,
    input logic [WAYS-1:0] lk_hit_vec
);
    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !lk_hit); // R1

    AST_SINGLE_WAY_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec)); // R3

    AST_GLOBAL_OFF_MISS: assert property (@(posedge clk) disable iff (rst)
        lk_req && cache_off |=> !lk_hit); // R5

    AST_PAGE_NC_MISS: assert property (@(posedge clk) disable iff (rst)
        lk_req && page_nc |=> !lk_hit); // R6

    AST_FLUSH_PIN_MISS: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !lk_hit); // R8

    AST_TEST_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
        tp_wr && (tp_sel == TP_CTRL) && (tp_cmd == 2'b11) |=> !lk_hit); // R12

    AST_RESET_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit); // R13
endmodule

bind tc_cache tc_cache_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_req     (lk_req),
    .lk_hit     (lk_hit),
    .cache_off  (cache_off),
    .page_nc    (page_nc),
    .flush_i    (flush_i),
    .tp_wr      (tp_wr),
    .tp_sel     (tp_sel),
    .tp_cmd     (tp_wdata[1:0]),
    .lk_hit_vec (lk_hit_vec)
);

// File: tb/tc_cache_tb_top.sv
module tc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:2] lk_addr = '0;
    logic        cache_off = 1'b0;
    logic        page_nc = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_data;
    logic        fill_valid = 1'b0;
    logic [31:4] fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic        ext_cacheable = 1'b1;
    logic        flush_i = 1'b0;
    logic        tp_wr = 1'b0;
    logic [1:0]  tp_sel = 2'd0;
    logic [31:0] tp_wdata = '0;
    logic [31:0] tp_rdata;

    always #2 clk = ~clk;

    tc_cache dut_i (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_addr(lk_addr),
        .cache_off(cache_off), .page_nc(page_nc), .lk_hit(lk_hit), .lk_data(lk_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .ext_cacheable(ext_cacheable), .flush_i(flush_i), .tp_wr(tp_wr),
        .tp_sel(tp_sel), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
    );

    // reference model
    logic [20:0]  m_tag   [4][128];
    logic [127:0] m_data  [4][128];
    bit           m_known [4][128];
    logic [3:0]   m_vld   [128];
    logic [2:0]   m_lru   [128];
    logic [31:0]  m_fb    [4];
    logic [31:0]  m_rb    [4];
    logic [31:0]  m_stat, m_ctrl;
    int n_tests = 0;
    int n_fail  = 0;

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        return {tag[20:0], set[6:0], word[1:0], 2'b00};
    endfunction

    function automatic logic [1:0] f_victim(input logic [2:0] l, input logic [3:0] v);
        for (int w = 0; w < 4; w++) if (!v[w]) return w[1:0];
        return l[0] ? (l[2] ? 2'd3 : 2'd2) : (l[1] ? 2'd1 : 2'd0);
    endfunction

    function automatic logic [2:0] f_touch(input logic [2:0] l, input logic [1:0] w);
        logic [2:0] n = l;
        if (w < 2) begin n[0] = 1'b1; n[1] = (w == 2'd0); end
        else       begin n[0] = 1'b0; n[2] = (w == 2'd2); end
        return n;
    endfunction

    function automatic int m_find(input logic [20:0] tag, input int set);
        for (int w = 0; w < 4; w++)
            if (m_vld[set][w] && m_tag[w][set] == tag) return w;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_flush();
        for (int s = 0; s < 128; s++) begin m_vld[s] = '0; m_lru[s] = '0; end
    endtask

    task automatic lookup(input logic [31:0] a, input bit cd, input bit pcd, input string req);
        int s = int'(a[10:4]);
        int w = m_find(a[31:11], s);
        bit eh = (w >= 0) && !cd && !pcd;
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a[31:2]; cache_off = cd; page_nc = pcd;
        @(negedge clk);
        lk_req = 1'b0; cache_off = 1'b0; page_nc = 1'b0;
        chk(lk_hit === eh, req, {31'b0, lk_hit}, {31'b0, eh});
        if (eh) begin
            chk(lk_data === m_data[w][s][int'(a[3:2])*32 +: 32], req, lk_data,
                m_data[w][s][int'(a[3:2])*32 +: 32]);
            m_lru[s] = f_touch(m_lru[s], w[1:0]);
        end
    endtask

    task automatic fill(input logic [31:0] a, input logic [127:0] line,
                        input bit cd, input bit pcd, input bit ken, output int way);
        int s = int'(a[10:4]);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            fill_valid = 1'b1; fill_addr = a[31:4]; fill_data = line[b*32 +: 32];
            cache_off = cd; page_nc = pcd; ext_cacheable = ken;
        end
        @(negedge clk);
        fill_valid = 1'b0; cache_off = 1'b0; page_nc = 1'b0; ext_cacheable = 1'b1;
        way = -1;
        if (!cd && !pcd && ken) begin
            logic [1:0] v = f_victim(m_lru[s], m_vld[s]);
            way = int'(v);
            m_tag[v][s] = a[31:11]; m_data[v][s] = line; m_known[v][s] = 1'b1;
            m_vld[s][v] = 1'b1; m_lru[s] = f_touch(m_lru[s], v);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush_i = 1'b1;
        @(negedge clk); flush_i = 1'b0;
        m_flush();
    endtask

    task automatic tp_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); tp_wr = 1'b1; tp_sel = sel; tp_wdata = d;
        @(negedge clk); tp_wr = 1'b0;
        case (sel)
            2'd0: m_fb[m_ctrl[3:2]] = d;
            2'd1: m_stat = {3'b0, d[28:0]};
            2'd2: begin
                int s = int'(d[10:4]);
                logic [1:0] e = d[3:2];
                m_ctrl = {21'b0, d[10:0]};
                case (d[1:0])
                    2'b01: begin
                        m_tag[e][s] = m_stat[20:0];
                        m_vld[s][e] = m_stat[21];
                        m_data[e][s] = {m_fb[3], m_fb[2], m_fb[1], m_fb[0]};
                        m_known[e][s] = 1'b1;
                    end
                    2'b10: begin
                        for (int k = 0; k < 4; k++) m_rb[k] = m_data[e][s][k*32 +: 32];
                        m_stat = {3'b0, m_vld[s], m_lru[s], m_vld[s][e], m_tag[e][s]};
                    end
                    2'b11: m_flush();
                    default: ;
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic tp_check(input logic [1:0] sel, input logic [31:0] exp, input string req);
        tp_sel = sel;
        #1;
        chk(tp_rdata === exp, req, tp_rdata, exp);
    endtask

    function automatic logic [31:0] ctl(input int set, input int entry, input logic [1:0] cmd);
        return {21'b0, set[6:0], entry[1:0], cmd};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int way;
        void'($urandom(32'd7781));
        m_flush();
        for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) m_known[w][s] = 1'b0;
        for (int k = 0; k < 4; k++) begin m_fb[k] = '0; m_rb[k] = '0; end
        m_stat = '0; m_ctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R13 reset state
        chk(lk_hit === 1'b0, "R13", {31'b0, lk_hit}, 32'h0);
        tp_check(2'd0, 32'h0, "R13");
        tp_check(2'd1, 32'h0, "R13");
        tp_check(2'd2, 32'h0, "R13");

        // R2 miss on empty cache
        lookup(mk(3, 5, 0), 0, 0, "R2");

        // R3 fill into empty set lands in way 0, R1 hits on every word
        fill(mk(3, 5, 0), 128'h44444444_33333333_22222222_11111111, 0, 0, 1, way);
        chk(way == 0, "R3", way, 0);
        for (int k = 0; k < 4; k++) lookup(mk(3, 5, k), 0, 0, "R1");
        tp_write(2'd2, ctl(5, 0, 2'b10));
        tp_check(2'd1, m_stat, "R11");
        chk(tp_rdata[21] === 1'b1 && tp_rdata[20:0] === 21'd3, "R3", tp_rdata, m_stat);

        // R9 read-buffer words through entry select
        for (int k = 0; k < 4; k++) begin
            tp_write(2'd2, ctl(5, k, 2'b00));
            tp_check(2'd0, m_rb[k], "R9");
        end
        for (int k = 0; k < 4; k++) begin
            tp_write(2'd2, ctl(20, k, 2'b00));
            tp_write(2'd0, 32'hA0A0_0000 + k);
        end

        // R10 test line write, then lookup hits
        tp_write(2'd1, {10'b0, 1'b1, 21'h1F});
        tp_write(2'd2, ctl(20, 3, 2'b01));
        for (int k = 0; k < 4; k++) lookup(mk(32'h1F, 20, k), 0, 0, "R10");
        tp_write(2'd2, ctl(20, 3, 2'b10));
        tp_check(2'd1, m_stat, "R11");
        chk(tp_rdata[28:25] === 4'b1000, "R11", tp_rdata, m_stat);

        // R7, R5, R6 fill gating and lookup gating
        fill(mk(4, 6, 0), 128'h1234, 0, 0, 0, way);
        lookup(mk(4, 6, 0), 0, 0, "R7");
        fill(mk(4, 6, 0), 128'h5678, 1, 0, 1, way);
        lookup(mk(4, 6, 0), 0, 0, "R5");
        lookup(mk(3, 5, 1), 1, 0, "R5");
        fill(mk(4, 6, 0), 128'h9ABC, 0, 1, 1, way);
        lookup(mk(4, 6, 0), 0, 0, "R6");
        lookup(mk(3, 5, 1), 0, 1, "R6");
        lookup(mk(3, 5, 1), 0, 0, "R1");

        // R4 pseudo-LRU replacement in a full set
        for (int t = 10; t < 14; t++) fill(mk(t, 9, 0), {4{t[31:0]}}, 0, 0, 1, way);
        lookup(mk(10, 9, 2), 0, 0, "R4");
        fill(mk(14, 9, 0), {4{32'hE}}, 0, 0, 1, way);
        chk(way == 2, "R4", way, 2);
        tp_write(2'd2, ctl(9, 2, 2'b10));
        tp_check(2'd1, m_stat, "R4");
        lookup(mk(12, 9, 0), 0, 0, "R4");
        lookup(mk(14, 9, 1), 0, 0, "R4");

        // R8 flush pin
        do_flush();
        lookup(mk(3, 5, 0), 0, 0, "R8");
        lookup(mk(32'h1F, 20, 0), 0, 0, "R8");

        // R12 flush command
        fill(mk(7, 1, 0), 128'hCAFE, 0, 0, 1, way);
        lookup(mk(7, 1, 0), 0, 0, "R1");
        tp_write(2'd2, ctl(0, 0, 2'b11));
        lookup(mk(7, 1, 0), 0, 0, "R12");

        // mixed random traffic on a small tag/set pool
        for (int i = 0; i < 700; i++) begin
            int op  = int'($urandom_range(0, 19));
            int tg  = int'($urandom_range(0, 5));
            int st  = int'($urandom_range(0, 3));
            int wd  = int'($urandom_range(0, 3));
            int en  = int'($urandom_range(0, 3));
            if (op < 9) begin
                lookup(mk(tg, st, wd), $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0, "R1");
            end else if (op < 14) begin
                if (m_find(tg[20:0], st) >= 0)
                    lookup(mk(tg, st, wd), 0, 0, "R1");
                else
                    fill(mk(tg, st, 0), {$urandom, $urandom, $urandom, $urandom},
                         $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                         $urandom_range(0, 5) != 0, way);
            end else if (op < 16) begin
                bit v = 1'b1;
                for (int w = 0; w < 4; w++)
                    if (w != en && m_vld[st][w] && m_tag[w][st] == tg[20:0]) v = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    tp_write(2'd2, ctl(st, k, 2'b00));
                    tp_write(2'd0, $urandom);
                end
                tp_write(2'd1, {10'b0, v, tg[20:0]});
                tp_write(2'd2, ctl(st, en, 2'b01));
            end else if (op < 19) begin
                if (m_known[en][st]) begin
                    tp_write(2'd2, ctl(st, en, 2'b10));
                    tp_check(2'd1, m_stat, "R11");
                    tp_check(2'd0, m_rb[en], "R9");
                end
            end else begin
                if ($urandom_range(0, 1) == 0) do_flush();
                else tp_write(2'd2, ctl(st, en, 2'b11));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule